// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A request carries the virtual address, whether the access is a write, and whether the requester is privileged. The walker reads the first-level descriptor, named by the upper twelve address bits. A section descriptor finishes the walk with a 1 MB mapping. A coarse-table descriptor leads to one more read, which fetches a small-page descriptor. Each walk ends with exactly one response. A response holds either the physical address, the domain and the cacheable and bufferable attributes, or a 4-bit fault status. Either way it echoes the virtual address of the request.

Descriptors are read through a memory port that has one request outstanding at a time. The upper bits of the table base and the 32-bit domain access word are inputs. Both are sampled when a request is accepted. The controller is a six-state machine:
- IDLE accepts a request and moves to FETCH_L1.
- FETCH_L1 holds the read until the acknowledge arrives, then moves to DECODE_L1.
- DECODE_L1 goes to FETCH_L2 for a coarse entry. Any other entry goes to RESPOND.
- FETCH_L2 waits for its acknowledge and then moves to DECODE_L2.
- DECODE_L2 always moves to RESPOND.
- RESPOND raises the response for one cycle and returns to IDLE.

Top module: `table_walker`

## Requirements
- R1: `req_ready` is high only in IDLE. Each accepted request produces exactly one single-cycle `rsp_valid` pulse, and `rsp_vaddr` equals the accepted address. After reset the block is ready, with no response and no memory read active.
- R2: The first-level read address is {`ttb_base`, vaddr[31:20], 2'b00}.
- R3: A first-level descriptor whose bits 1:0 are 0 (fault) or 3 (unsupported fine table) gives status 5 with domain 0. No second read is made.
- R4: A section descriptor has bits 1:0 equal to 2. Its physical address is descriptor[31:20] joined with vaddr[19:0], its domain is descriptor[8:5], cacheable is bit 3 and bufferable is bit 2.
- R5: A coarse descriptor has bits 1:0 equal to 1. It causes a second read at {descriptor[31:10], vaddr[19:12], 2'b00}.
- R6: A second-level descriptor whose bits 1:0 are 0, 1 or 3 gives status 7. Only type 2 (small page) can complete.
- R7: A small page maps to second-level descriptor[31:12] joined with vaddr[11:0]. Cacheable and bufferable come from bits 3 and 2 of the second-level descriptor. The domain comes from the first-level descriptor[8:5].
- R8: The domain's 2-bit field is `dom_access`[2d+1:2d]. A value of 0 (no access) or 2 (reserved) gives status 9 for a section or 11 for a page.
- R9: A domain field of 3 skips the permission check, so access is allowed even when the permission field is 0.
- R10: With a domain field of 1, the permission field decides:
  - 0 denies every access.
  - 1 allows privileged access only.
  - 2 allows privileged access, and user reads only.
  - 3 allows every access.
  A denied access gives status 13 for a section or 15 for a page. A section's permission field is descriptor[11:10].
- R11: A small page's permission field is taken from bits [2q+5:2q+4] of its descriptor, where q is vaddr[11:10].
- R12: `mem_req` stays high with `mem_addr` unchanged until `mem_ack`. An `mem_ack` seen while no read is pending has no effect.
- R13: A faulting response has `rsp_fault`=1, `rsp_paddr`=0 and cacheable=bufferable=0. A successful response has status 0 and `rsp_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_status | output | 4 | Fault status, 0 on success |
| rsp_vaddr | output | 32 | Virtual address of the request |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_domain | output | 4 | Domain of the first-level entry |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| mem_req | output | 1 | Descriptor read pending |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| ttb_base | input | 18 | Table base address bits 31:14 |
| dom_access | input | 32 | Sixteen 2-bit domain access fields |

## Verification
The embedded properties check the following on every cycle:
- the response is a single-cycle pulse;
- the walker is never ready while a read is pending;
- a pending read keeps its address until acknowledged;
- a fault response carries an odd status and a zero address, and a success carries status 0;
- nothing is fetched after a first-level descriptor that is not a coarse entry;
- a completed section keeps the low twenty address bits.

Only the scoreboard scenarios can show the rest, because each needs a prepared table and a compared result. These are the read addresses at both levels, the decode of every descriptor type, the domain and permission outcomes for privileged and user accesses, the choice of permission quarter inside a small page, and the handling of a stray acknowledge.

// File: rtl/twalk_pkg.sv
package twalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_L1,
        ST_DECODE_L1,
        ST_FETCH_L2,
        ST_DECODE_L2,
        ST_RESPOND
    } walk_state_e;

    typedef enum logic [1:0] {
        L1_FAULT   = 2'd0,
        L1_COARSE  = 2'd1,
        L1_SECTION = 2'd2,
        L1_FINE    = 2'd3
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'd0,
        L2_LARGE = 2'd1,
        L2_SMALL = 2'd2,
        L2_TINY  = 2'd3
    } l2_kind_e;

    localparam logic [3:0] ST_OK          = 4'd0;
    localparam logic [3:0] ST_XLATE_SECT  = 4'd5;
    localparam logic [3:0] ST_XLATE_PAGE  = 4'd7;
    localparam logic [3:0] ST_DOMAIN_SECT = 4'd9;
    localparam logic [3:0] ST_DOMAIN_PAGE = 4'd11;
    localparam logic [3:0] ST_PERM_SECT   = 4'd13;
    localparam logic [3:0] ST_PERM_PAGE   = 4'd15;

    localparam logic [1:0] DOM_NONE     = 2'd0;
    localparam logic [1:0] DOM_CLIENT   = 2'd1;
    localparam logic [1:0] DOM_RESERVED = 2'd2;
    localparam logic [1:0] DOM_MANAGER  = 2'd3;

endpackage

// File: rtl/twalk_addr_gen.sv
module twalk_addr_gen #(
    parameter int VA_W     = 32,
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8
) (
    input  logic [VA_W-L1_IDX_W-3:0] tbl_base,
    input  logic [L1_IDX_W-1:0]      l1_idx,
    input  logic [VA_W-L2_IDX_W-3:0] l2_base,
    input  logic [L2_IDX_W-1:0]      l2_idx,
    input  logic                     use_l2,
    output logic [VA_W-1:0]          fetch_addr
);

    logic [VA_W-1:0] l1_addr;
    logic [VA_W-1:0] l2_addr;

    // Word-aligned entry addresses: base, index, two zero byte bits.
    assign l1_addr = {tbl_base, l1_idx, 2'b00};
    assign l2_addr = {l2_base, l2_idx, 2'b00};

    always_comb begin
        fetch_addr = use_l2 ? l2_addr : l1_addr;
    end

endmodule

// File: rtl/twalk_access_chk.sv
module twalk_access_chk
    import twalk_pkg::*;
#(
    parameter int DOM_W = 4,
    parameter int QTR_N = 4
) (
    input  logic [2*QTR_N-1:0]        ap_bits,
    input  logic                      is_page,
    input  logic [$clog2(QTR_N)-1:0]  quarter,
    input  logic [DOM_W-1:0]          domain,
    input  logic [2*(2**DOM_W)-1:0]   dom_access,
    input  logic                      is_write,
    input  logic                      is_priv,
    output logic                      dom_fault,
    output logic                      perm_fault
);

    logic [1:0] ap_fld [QTR_N];
    logic [1:0] ap_sel;
    logic [1:0] dom_fld;
    logic       allowed;

    for (genvar g = 0; g < QTR_N; g++) begin : g_ap
        assign ap_fld[g] = ap_bits[2*g +: 2];
    end

    always_comb begin
        // A section keeps its single field in the topmost slot.
        ap_sel  = is_page ? ap_fld[quarter] : ap_fld[QTR_N-1];
        dom_fld = dom_access[2*domain +: 2];
        unique case (ap_sel)
            2'd0:    allowed = 1'b0;
            2'd1:    allowed = is_priv;
            2'd2:    allowed = is_priv || !is_write;
            default: allowed = 1'b1;
        endcase
        dom_fault  = (dom_fld == DOM_NONE) || (dom_fld == DOM_RESERVED);
        perm_fault = (dom_fld == DOM_CLIENT) && !allowed;
    end

endmodule

// File: rtl/table_walker.sv
module table_walker
    import twalk_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8,
    parameter int DOM_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [VA_W-1:0]                req_vaddr,
    input  logic                           req_write,
    input  logic                           req_priv,
    output logic                           rsp_valid,
    output logic                           rsp_fault,
    output logic [3:0]                     rsp_status,
    output logic [VA_W-1:0]                rsp_vaddr,
    output logic [VA_W-1:0]                rsp_paddr,
    output logic [DOM_W-1:0]               rsp_domain,
    output logic                           rsp_cacheable,
    output logic                           rsp_bufferable,
    output logic                           mem_req,
    output logic [VA_W-1:0]                mem_addr,
    input  logic                           mem_ack,
    input  logic [VA_W-1:0]                mem_rdata,
    input  logic [VA_W-L1_IDX_W-3:0]       ttb_base,
    input  logic [2*(2**DOM_W)-1:0]        dom_access
);

    localparam int SECT_OFF_W = VA_W - L1_IDX_W;
    localparam int PAGE_OFF_W = SECT_OFF_W - L2_IDX_W;
    localparam int L2_BASE_W  = VA_W - L2_IDX_W - 2;
    localparam int DACR_W     = 2 * (2**DOM_W);
    localparam int DOM_LSB    = 5;
    localparam int QTR_LSB    = PAGE_OFF_W - 2;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]            va_q;
    logic                       wr_q, priv_q;
    logic [VA_W-L1_IDX_W-3:0]   ttb_q;
    logic [DACR_W-1:0]          dacr_q;
    logic [VA_W-1:0]            l1_q, l2_q;

    logic                       out_fault_q;
    logic [3:0]                 out_status_q;
    logic [VA_W-1:0]            out_paddr_q;
    logic [DOM_W-1:0]           out_dom_q;
    logic                       out_c_q, out_b_q;

    logic                       is_page;
    logic [VA_W-1:0]            chk_desc;
    logic [DOM_W-1:0]           l1_dom;
    logic                       dom_fault, perm_fault;
    logic                       res_fault;
    logic [3:0]                 res_status;
    logic [VA_W-1:0]            res_paddr;
    logic [DOM_W-1:0]           res_dom;
    logic                       res_c, res_b;
    logic                       unused_ok;

    assign unused_ok = ^{l1_q[9], l1_q[4]};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_FETCH_L1;
            ST_FETCH_L1:  if (mem_ack)   state_d = ST_DECODE_L1;
            ST_DECODE_L1: state_d = (l1_q[1:0] == L1_COARSE) ? ST_FETCH_L2 : ST_RESPOND;
            ST_FETCH_L2:  if (mem_ack)   state_d = ST_DECODE_L2;
            ST_DECODE_L2: state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // ---------------- address and permission helpers ----------------
    twalk_addr_gen #(
        .VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)
    ) u_addr (
        .tbl_base   (ttb_q),
        .l1_idx     (va_q[VA_W-1:SECT_OFF_W]),
        .l2_base    (l1_q[VA_W-1:VA_W-L2_BASE_W]),
        .l2_idx     (va_q[SECT_OFF_W-1:PAGE_OFF_W]),
        .use_l2     (state_q == ST_FETCH_L2),
        .fetch_addr (mem_addr)
    );

    assign is_page  = (state_q == ST_DECODE_L2);
    assign chk_desc = is_page ? l2_q : l1_q;
    assign l1_dom   = l1_q[DOM_LSB +: DOM_W];

    twalk_access_chk #(.DOM_W(DOM_W), .QTR_N(4)) u_chk (
        .ap_bits    (chk_desc[11:4]),
        .is_page    (is_page),
        .quarter    (va_q[QTR_LSB +: 2]),
        .domain     (l1_dom),
        .dom_access (dacr_q),
        .is_write   (wr_q),
        .is_priv    (priv_q),
        .dom_fault  (dom_fault),
        .perm_fault (perm_fault)
    );

    // Result of the decode stage; precedence: type, domain, permission.
    always_comb begin
        res_fault  = 1'b0;
        res_status = ST_OK;
        res_paddr  = '0;
        res_dom    = l1_dom;
        res_c      = 1'b0;
        res_b      = 1'b0;
        if (!is_page) begin
            if (l1_q[1:0] != L1_SECTION) begin
                res_fault  = 1'b1;
                res_status = ST_XLATE_SECT;
                res_dom    = '0;
            end else if (dom_fault) begin
                res_fault  = 1'b1;
                res_status = ST_DOMAIN_SECT;
            end else if (perm_fault) begin
                res_fault  = 1'b1;
                res_status = ST_PERM_SECT;
            end else begin
                res_paddr = {l1_q[VA_W-1:SECT_OFF_W], va_q[SECT_OFF_W-1:0]};
                res_c     = l1_q[3];
                res_b     = l1_q[2];
            end
        end else begin
            if (l2_q[1:0] != L2_SMALL) begin
                res_fault  = 1'b1;
                res_status = ST_XLATE_PAGE;
            end else if (dom_fault) begin
                res_fault  = 1'b1;
                res_status = ST_DOMAIN_PAGE;
            end else if (perm_fault) begin
                res_fault  = 1'b1;
                res_status = ST_PERM_PAGE;
            end else begin
                res_paddr = {l2_q[VA_W-1:PAGE_OFF_W], va_q[PAGE_OFF_W-1:0]};
                res_c     = l2_q[3];
                res_b     = l2_q[2];
            end
        end
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q         <= '0;
            wr_q         <= 1'b0;
            priv_q       <= 1'b0;
            ttb_q        <= '0;
            dacr_q       <= '0;
            l1_q         <= '0;
            l2_q         <= '0;
            out_fault_q  <= 1'b0;
            out_status_q <= ST_OK;
            out_paddr_q  <= '0;
            out_dom_q    <= '0;
            out_c_q      <= 1'b0;
            out_b_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    priv_q <= req_priv;
                    ttb_q  <= ttb_base;
                    dacr_q <= dom_access;
                end
                ST_FETCH_L1: if (mem_ack) l1_q <= mem_rdata;
                ST_FETCH_L2: if (mem_ack) l2_q <= mem_rdata;
                ST_DECODE_L1, ST_DECODE_L2: begin
                    if (is_page || l1_q[1:0] != L1_COARSE) begin
                        out_fault_q  <= res_fault;
                        out_status_q <= res_status;
                        out_paddr_q  <= res_paddr;
                        out_dom_q    <= res_dom;
                        out_c_q      <= res_c;
                        out_b_q      <= res_b;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        mem_req        = (state_q == ST_FETCH_L1) || (state_q == ST_FETCH_L2);
        rsp_valid      = (state_q == ST_RESPOND);
        rsp_fault      = out_fault_q;
        rsp_status     = out_status_q;
        rsp_vaddr      = va_q;
        rsp_paddr      = out_paddr_q;
        rsp_domain     = out_dom_q;
        rsp_cacheable  = out_c_q;
        rsp_bufferable = out_b_q;
    end

    // ---------------- assertions ----------------
    // R1
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R13
    fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_status[0] && rsp_status >= ST_XLATE_SECT
                                      && rsp_paddr == '0 && !rsp_cacheable && !rsp_bufferable));

    // R13
    ok_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_status == ST_OK));

    // R3
    no_l2_after_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE_L1 && l1_q[1:0] != L1_COARSE) |=> (!mem_req && rsp_valid));

    // R4
    section_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE_L1 && l1_q[1:0] == L1_SECTION && !dom_fault && !perm_fault)
        |=> (rsp_valid && rsp_paddr[SECT_OFF_W-1:0] == rsp_vaddr[SECT_OFF_W-1:0]));

endmodule

// File: tb/tb_table_walker.sv
`timescale 1ns/1ps
module tb_table_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [3:0]  rsp_status;
    logic [31:0] rsp_vaddr, rsp_paddr;
    logic [3:0]  rsp_domain;
    logic        rsp_cacheable, rsp_bufferable;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [17:0] ttb_base = '0;
    logic [31:0] dom_access = '0;

    always #4 clk = ~clk;

    table_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_status(rsp_status),
        .rsp_vaddr(rsp_vaddr), .rsp_paddr(rsp_paddr), .rsp_domain(rsp_domain),
        .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ttb_base(ttb_base), .dom_access(dom_access)
    );

    typedef struct {
        logic [31:0] vaddr;
        logic        fault;
        logic [3:0]  status;
        logic [31:0] paddr;
        logic [3:0]  domain;
        logic        c;
        logic        b;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] fetch_q[$];
    logic [31:0] mem [logic [31:0]];
    int          errors = 0;
    int          checks = 0;
    int          dly_sel = 0;
    int          wcnt = 0;
    bit          spurious = 1'b0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit perm_ok(input logic [1:0] ap, input bit wr, input bit pv);
        case (ap)
            2'd0:    return 1'b0;
            2'd1:    return pv;
            2'd2:    return pv || !wr;
            default: return 1'b1;
        endcase
    endfunction

    // Reference model built from the requirements; pushes expected fetches and result.
    task automatic predict(input logic [31:0] va, input bit wr, input bit pv, input string tag);
        exp_t        e;
        logic [31:0] a1, a2, d1, d2;
        logic [3:0]  dm;
        logic [1:0]  df, ap;
        e.vaddr = va; e.fault = 1'b0; e.status = 4'd0; e.paddr = '0;
        e.domain = '0; e.c = 1'b0; e.b = 1'b0; e.tag = tag;
        a1 = {ttb_base, va[31:20], 2'b00};
        fetch_q.push_back(a1);
        d1 = rd(a1);
        dm = d1[8:5];
        df = dom_access[2*dm +: 2];
        if (d1[1:0] == 2'd2) begin
            e.domain = dm;
            ap = d1[11:10];
            if (df == 2'd0 || df == 2'd2) begin e.fault = 1; e.status = 4'd9; end
            else if (df == 2'd1 && !perm_ok(ap, wr, pv)) begin e.fault = 1; e.status = 4'd13; end
            else begin e.paddr = {d1[31:20], va[19:0]}; e.c = d1[3]; e.b = d1[2]; end
        end else if (d1[1:0] == 2'd1) begin
            e.domain = dm;
            a2 = {d1[31:10], va[19:12], 2'b00};
            fetch_q.push_back(a2);
            d2 = rd(a2);
            ap = d2[4 + 2*va[11:10] +: 2];
            if (d2[1:0] != 2'd2) begin e.fault = 1; e.status = 4'd7; end
            else if (df == 2'd0 || df == 2'd2) begin e.fault = 1; e.status = 4'd11; end
            else if (df == 2'd1 && !perm_ok(ap, wr, pv)) begin e.fault = 1; e.status = 4'd15; end
            else begin e.paddr = {d2[31:12], va[11:0]}; e.c = d2[3]; e.b = d2[2]; end
        end else begin
            e.fault = 1; e.status = 4'd5;
        end
        exp_q.push_back(e);
    endtask

    // Driver: predict, issue, wait for the monitor to consume the response.
    task automatic walk(input logic [31:0] va, input bit wr, input bit pv, input string tag);
        predict(va, wr, pv, tag);
        while (!req_ready) @(negedge clk);
        req_vaddr = va; req_write = wr; req_priv = pv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        check(fetch_q.size() == 0, "R3", {tag, " all expected reads made, none extra"},
              fetch_q.size(), 0);
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "response without request", rsp_vaddr, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (rsp_vaddr !== e.vaddr || rsp_fault !== e.fault || rsp_status !== e.status ||
                        rsp_paddr !== e.paddr || rsp_domain !== e.domain ||
                        rsp_cacheable !== e.c || rsp_bufferable !== e.b) begin
                        errors++;
                        $display("FAIL %s: actual va=%h f=%b st=%0d pa=%h dom=%0d cb=%b%b expected va=%h f=%b st=%0d pa=%h dom=%0d cb=%b%b",
                                 e.tag, rsp_vaddr, rsp_fault, rsp_status, rsp_paddr, rsp_domain,
                                 rsp_cacheable, rsp_bufferable, e.vaddr, e.fault, e.status,
                                 e.paddr, e.domain, e.c, e.b);
                    end
                end
            end
        end
    end

    // Memory responder with 0..2 cycles of wait
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (spurious) begin
                mem_rdata = 32'hFFFF_FFFF;
                mem_ack   = 1'b1;
                spurious  = 1'b0;
            end else if (rst_n && mem_req) begin
                if (wcnt == 0) check(!req_ready, "R1", "ready low during walk", req_ready, 0);
                if (wcnt < dly_sel) begin
                    wcnt++;
                end else begin
                    if (fetch_q.size() == 0) begin
                        check(1'b0, "R3", "unexpected descriptor read", mem_addr, 0);
                    end else begin
                        logic [31:0] ea;
                        ea = fetch_q.pop_front();
                        check(mem_addr == ea, "R2/R5", "descriptor read address", mem_addr, ea);
                    end
                    mem_rdata = rd(mem_addr);
                    mem_ack   = 1'b1;
                    wcnt      = 0;
                    dly_sel   = (dly_sel + 1) % 3;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Table at 0x0010_0000
        mem[32'h0010_0000] = 32'h8000_0C3E; // idx0 section dom1 AP3 CB=11
        mem[32'h0010_0004] = 32'h0000_0010; // idx1 fault
        mem[32'h0010_0008] = 32'h0000_0013; // idx2 fine (unsupported)
        mem[32'h0010_000C] = 32'h0020_0451; // idx3 coarse dom2 -> 0x0020_0400
        mem[32'h0010_0010] = 32'h9000_0072; // idx4 section dom3 AP0
        mem[32'h0010_0014] = 32'hA000_0C12; // idx5 section dom0
        mem[32'h0010_0018] = 32'hB000_0C92; // idx6 section dom4 (reserved)
        mem[32'h0010_001C] = 32'hC000_04BA; // idx7 section dom5 AP1 C only
        mem[32'h0010_0020] = 32'hD000_0836; // idx8 section dom1 AP2 B only
        mem[32'h0010_0024] = 32'h0020_08D1; // idx9 coarse dom6 -> 0x0020_0800
        mem[32'h0010_0028] = 32'h0020_0CF1; // idx10 coarse dom7 -> 0x0020_0C00
        mem[32'h0020_0400] = 32'h4567_8E46; // small, quarters AP 0,1,2,3, CB=01
        mem[32'h0020_0404] = 32'h1111_1FF0; // fault
        mem[32'h0020_0408] = 32'h2222_2FF1; // large (unsupported)
        mem[32'h0020_040C] = 32'h3333_3FF3; // tiny (unsupported)
        mem[32'h0020_0800] = 32'h1234_5FFE; // small, all AP3
        mem[32'h0020_0C14] = 32'h6789_A00E; // small, all AP0, CB=11
        // Second table at 0x0040_0000
        mem[32'h0040_0000] = 32'hE000_0C3E;

        repeat (4) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
        check(mem_req == 1'b0, "R1", "reset mem_req", mem_req, 0);
        rst_n = 1'b1;
        ttb_base   = 18'h00040;
        dom_access = 32'h0000_C6D4;
        repeat (2) @(negedge clk);

        walk(32'h000A_BCDE, 1'b1, 1'b0, "R4 section user write");
        walk(32'h0015_5555, 1'b0, 1'b1, "R3 R13 fault entry");
        walk(32'h0020_0000, 1'b0, 1'b1, "R3 R13 fine entry");
        walk(32'h0030_0C12, 1'b1, 1'b0, "R7 R11 quarter3 user write");
        walk(32'h0030_0034, 1'b0, 1'b1, "R11 R10 quarter0 priv read denied");
        walk(32'h0030_0400, 1'b0, 1'b0, "R11 R10 quarter1 user read denied");
        walk(32'h0030_0400, 1'b1, 1'b1, "R11 R10 quarter1 priv write");
        walk(32'h0030_0800, 1'b0, 1'b0, "R11 R10 quarter2 user read");
        walk(32'h0030_0800, 1'b1, 1'b0, "R11 R10 quarter2 user write denied");
        walk(32'h0030_1000, 1'b0, 1'b1, "R6 page fault type");
        walk(32'h0030_2000, 1'b0, 1'b1, "R6 large page type");
        walk(32'h0030_3000, 1'b0, 1'b1, "R6 tiny page type");
        walk(32'h004F_0001, 1'b1, 1'b0, "R9 manager section AP0");
        walk(32'h0050_0000, 1'b0, 1'b1, "R8 section no-access domain");
        walk(32'h0060_0000, 1'b0, 1'b1, "R8 section reserved domain");
        walk(32'h0070_0000, 1'b0, 1'b0, "R10 AP1 user read denied");
        walk(32'h0071_2345, 1'b1, 1'b1, "R10 AP1 priv write");
        walk(32'h0080_0000, 1'b0, 1'b0, "R10 AP2 user read");
        walk(32'h0080_0000, 1'b1, 1'b0, "R10 AP2 user write denied");
        walk(32'h0080_0FFF, 1'b1, 1'b1, "R10 AP2 priv write");
        walk(32'h0090_0ABC, 1'b0, 1'b1, "R8 page no-access domain");
        walk(32'h00A0_5F0F, 1'b1, 1'b0, "R9 manager page AP0");

        // R12: acknowledge while idle is ignored
        @(negedge clk);
        spurious = 1'b1;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R12", "no response after stray ack", rsp_valid, 0);
        check(req_ready == 1'b1, "R12", "still idle after stray ack", req_ready, 1);
        walk(32'h0000_0004, 1'b0, 1'b0, "R12 walk after stray ack");

        // R2: new table base, including the last entry of the table
        ttb_base = 18'h00100;
        walk(32'h0001_2345, 1'b0, 1'b1, "R2 second table section");
        walk(32'hFFF0_0000, 1'b0, 1'b1, "R2 R3 last table entry");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule